// File: doc/BRIEF.md
# Converter output-stage guard and deglitch controller

This controller sequences the two switches around a converter's output buffer. One switch joins the amplifier to the output pin and the other ties the pin to ground. While the supplies are bad, or the external active-low reset is driven low, the pin stays tied to ground and the amplifier stays isolated. The pin is released only after the supplies are good and a new word has been written to the data register while the reset input is high. Every change between the two switches opens the closed switch one clock before the other switch closes.

Independently, the controller watches an active-low load strobe. It synchronizes the strobe, finds its high-to-low edges, and holds the output buffer for a fixed number of clocks after each edge. A new edge during a hold restarts the count. The supply-good indication is also passed out for use by other logic. `supply_ok_i`, `ext_rst_n_i` and `wr_i` are synchronous to `clk`. `load_n_i` may be asynchronous.

Top module: `outstage_guard`

## Requirements
- R1: After `rst_n` is released, `clamp_on_o`=1, `amp_on_o`=0 and `hold_o`=0. A gate output of 1 means that switch is closed (conducting).
- R2: If `wr_i` is sampled high while `supply_ok_i`=1 and `ext_rst_n_i`=1, `clamp_on_o` falls at the next rising edge and `amp_on_o` rises one edge after that.
- R3: A `wr_i` pulse sampled while `supply_ok_i`=0 or `ext_rst_n_i`=0 leaves the output clamped.
- R4: If `supply_ok_i` goes low while the output is driven, `amp_on_o` falls at the next edge and `clamp_on_o` rises one edge later. The record of the write is cleared, so the output stays clamped after the supply recovers until a new write arrives.
- R5: `ext_rst_n_i`=0 forces the same release sequence as R4 at any time. Only a write sampled with `ext_rst_n_i`=1 re-enables the output.
- R6: `amp_on_o` and `clamp_on_o` are never 1 together. Each rises only if the other was 0 in the previous cycle.
- R7: A high-to-low edge on `load_n_i` makes `hold_o` rise at the third rising edge after the edge, and stay high for exactly HOLD_CYCLES cycles.
- R8: A new high-to-low edge while `hold_o`=1 restarts the full HOLD_CYCLES count.
- R9: When `load_n_i` stays at a constant level, whether low or high, no hold window is generated.
- R10: `supply_ok_o` equals `supply_ok_i` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supplies stable (1 = good) |
| ext_rst_n_i | input | 1 | External active-low output reset |
| wr_i | input | 1 | Data register write strobe, one cycle |
| load_n_i | input | 1 | Active-low load strobe, asynchronous |
| amp_on_o | output | 1 | Amplifier-to-pin switch closed |
| clamp_on_o | output | 1 | Pin-to-ground switch closed |
| hold_o | output | 1 | Output buffer in hold (1) or track (0) |
| supply_ok_o | output | 1 | Copy of the supply-good state |

## Verification
Some properties are checked by assertions on every cycle:
- the two switches are never closed together, and each closes only after the other was open the previous cycle;
- a supply or reset fault opens the amplifier switch at the next edge;
- a detected load edge always produces a hold.

Some behaviour can only be shown by the bench's scenarios, with a cycle-accurate model compared every clock:
- the exact edge on which each switch moves;
- that a write is ignored during a fault;
- that the output stays clamped after supply recovery until a new write arrives;
- the exact hold length, including a restarted window and a strobe held permanently low.

// File: rtl/outstage_guard.sv
module outstage_guard #(
  parameter int HOLD_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic ext_rst_n_i,
  input  logic wr_i,
  input  logic load_n_i,
  output logic amp_on_o,
  output logic clamp_on_o,
  output logic hold_o,
  output logic supply_ok_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic                   word_ok;
  logic [SYNC_STAGES-1:0] ld_sync;
  logic                   ld_prev;
  logic [CW-1:0]          hold_cnt;

  wire fault   = !supply_ok_i || !ext_rst_n_i;
  wire want    = word_ok && !fault;
  wire ld_s    = ld_sync[SYNC_STAGES-1];
  wire ld_fall = ld_prev && !ld_s;

  assign supply_ok_o = supply_ok_i;
  assign hold_o      = hold_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_ok    <= 1'b0;
      amp_on_o   <= 1'b0;
      clamp_on_o <= 1'b1;
    end else begin
      if (fault)     word_ok <= 1'b0;
      else if (wr_i) word_ok <= 1'b1;
      amp_on_o   <= want && !clamp_on_o;
      clamp_on_o <= !want && !amp_on_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sync  <= '1;
      ld_prev  <= 1'b1;
      hold_cnt <= '0;
    end else begin
      ld_sync <= {ld_sync[SYNC_STAGES-2:0], load_n_i};
      ld_prev <= ld_s;
      if (ld_fall)          hold_cnt <= CW'(HOLD_CYCLES);
      else if (hold_o)      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(amp_on_o && clamp_on_o));
  a_r6_amp_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_on_o) |-> !$past(clamp_on_o));
  a_r6_clamp_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_on_o) |-> !$past(amp_on_o));
  a_r4_fault_opens_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_i || !ext_rst_n_i) |=> !amp_on_o);
  a_r3_drive_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_on_o) |-> $past(word_ok));
  a_r7_edge_starts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> hold_o);
endmodule

// File: tb/outstage_guard_bench.sv
module outstage_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 24;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, ext_rst_n = 1, wr = 0, load_n = 1;
  logic amp_on, clamp_on, hold, sup_out;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit m_amp, m_clamp, m_valid, m_ready;
  bit s1, s2, prv;
  int m_cnt;

  outstage_guard #(.HOLD_CYCLES(HOLD)) u_outstage_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .ext_rst_n_i(ext_rst_n),
    .wr_i(wr), .load_n_i(load_n), .amp_on_o(amp_on), .clamp_on_o(clamp_on),
    .hold_o(hold), .supply_ok_o(sup_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated from the inputs at each rising edge
  always @(posedge clk) begin
    bit fault, want, n_amp, n_clamp, fall;
    cycles++;
    if (!rst_n) begin
      m_amp = 0; m_clamp = 1; m_valid = 0; m_cnt = 0;
      s1 = 1; s2 = 1; prv = 1;
    end else begin
      fault = !supply_ok || !ext_rst_n;
      want = m_valid && !fault;
      n_amp = want && !m_clamp;
      n_clamp = !want && !m_amp;
      m_amp = n_amp; m_clamp = n_clamp;
      if (fault) m_valid = 0; else if (wr) m_valid = 1;
      fall = prv && !s2;
      prv = s2; s2 = s1; s1 = load_n;
      if (fall) m_cnt = HOLD; else if (m_cnt > 0) m_cnt--;
    end
    m_ready = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (m_ready) begin
    vectors++;
    chk("R2/R4/R5 amp_on", amp_on, m_amp);
    chk("R2/R4/R5 clamp_on", clamp_on, m_clamp);
    chk("R7/R8/R9 hold", hold, m_cnt > 0);
    chk("R10 supply_ok_o", sup_out, supply_ok);
    chk("R6 both closed", amp_on && clamp_on, 0);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_word();
    wr = 1; tick(1); wr = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 clamp after reset", clamp_on, 1);
    chk("R1 amp after reset", amp_on, 0);
    chk("R1 hold after reset", hold, 0);

    // R3: writes during a fault are ignored
    write_word(); tick(4);
    chk("R3 write with supply low", clamp_on, 1);
    supply_ok = 1; ext_rst_n = 0; tick(1);
    write_word(); tick(4);
    chk("R3 write with reset low", clamp_on, 1);
    ext_rst_n = 1; tick(4);
    chk("R3 no stale write", amp_on, 0);

    // R2 and R6: release sequence
    wr = 1; tick(1); wr = 0;
    chk("R2 clamp still closed", clamp_on, 1);
    tick(1);
    chk("R6 gap clamp", clamp_on, 0);
    chk("R6 gap amp", amp_on, 0);
    tick(1);
    chk("R2 amp closed", amp_on, 1);

    // R10: status follows the supply input, and R4: supply drop
    tick(3);
    supply_ok = 0; tick(1);
    chk("R10 status low", sup_out, 0);
    chk("R4 amp opens", amp_on, 0);
    chk("R4 gap clamp", clamp_on, 0);
    tick(1);
    chk("R4 clamp closes", clamp_on, 1);
    supply_ok = 1; tick(6);
    chk("R4 stays clamped after recovery", clamp_on, 1);
    chk("R10 status high", sup_out, 1);
    write_word(); tick(3);
    chk("R4 re-enabled by write", amp_on, 1);

    // R5: external reset
    ext_rst_n = 0; tick(3);
    chk("R5 clamp on reset", clamp_on, 1);
    ext_rst_n = 1; tick(5);
    chk("R5 stays clamped", clamp_on, 1);
    write_word(); tick(3);
    chk("R5 re-enabled", amp_on, 1);

    // R7: one hold window of exact length
    begin
      int hc = 0;
      load_n = 0; tick(2);
      chk("R7 hold not yet", hold, 0);
      tick(1);
      chk("R7 hold starts", hold, 1);
      load_n = 1;
      for (int i = 0; i < HOLD + 10; i++) begin
        if (hold) hc++;
        tick(1);
      end
      chk("R7 hold length", hc, HOLD);
    end

    // R8: restart during hold
    load_n = 0; tick(2); load_n = 1; tick(HOLD/2);
    load_n = 0; tick(2); load_n = 1;
    tick(HOLD);
    chk("R8 hold extended", hold, 1);
    tick(HOLD);
    chk("R8 hold ends", hold, 0);

    // R9: strobe held low, then held high
    load_n = 0; tick(HOLD + 8);
    chk("R9 steady low no hold", hold, 0);
    tick(3 * HOLD);
    chk("R9 still no hold", hold, 0);
    load_n = 1; tick(2 * HOLD);
    chk("R9 steady high no hold", hold, 0);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule